// File: doc/BRIEF.md
# Serial Self-Test Word Transmitter

This block takes a 32-bit test word from a command port and sends it as a three-level ARINC 429 style serial stream on a pair of digital outputs. One output is high for a logic one and the other is high for a logic zero. When both are low, the line is null. The command code picks the bit rate for each word. Code 8 selects the high rate and code 9 selects the low rate. The word goes out starting with its bit 0, which is the least significant bit in ARINC terms.

Each bit occupies two half-periods. The first half carries the data level and the second half is null. A half-period lasts CLK_HZ/(2*bit rate) clock cycles, taken from an internal clock-enable divider. After the last bit, at least four bit-times of null follow. The busy flag stays high until that gap is over.

The same stream is routed to a set of receiver channels. Each channel has a loopback enable, which is active low. When a channel's enable is 0, its receive pair takes the internal stream. When the enable is 1, the receive pair follows the channel's external line input. The output pair always carries the stream, whatever the loopback settings are.

Top module: `a429_st_tx`

## Requirements
- R1: While rst_n is low, line_pos, line_neg and busy are all 0.
- R2: A cmd_valid pulse with cmd_code 4'h8 while idle starts a word at the high rate. Each half-period lasts CLK_HZ/(2*HI_BPS) cycles, and the first half-period begins in the cycle after the accepting clock edge.
- R3: A cmd_valid pulse with cmd_code 4'h9 while idle starts a word at the low rate. Each half-period lasts CLK_HZ/(2*LO_BPS) cycles.
- R4: Bit i of cmd_word is the i-th bit transmitted, so bit 0 goes out first.
- R5: In the first half of a bit, a one shows as (line_pos,line_neg)=(1,0) and a zero shows as (0,1). The second half of every bit is null (0,0).
- R6: After the last of the 32 bits, the pair stays null for 4 bit-times with busy high. Busy falls at the end of that gap.
- R7: A command that arrives while busy is ignored. The word in flight and its rate are unchanged.
- R8: A cmd_valid pulse with any code other than 4'h8 or 4'h9 is ignored, and busy stays 0.
- R9: For each channel c, rx_pos[c]/rx_neg[c] equal line_pos/line_neg when loop_en_n[c] is 0. They equal ext_pos[c]/ext_neg[c] when loop_en_n[c] is 1.
- R10: While busy is 0, line_pos and line_neg are both 0.
- R11: The output pair carries the stream whatever the value of loop_en_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 4 | Command low nibble: 8 = high rate, 9 = low rate |
| cmd_word | input | 32 | Test word to transmit |
| busy | output | 1 | High from acceptance until the end of the trailing gap |
| line_pos | output | 1 | High while a logic one is driven |
| line_neg | output | 1 | High while a logic zero is driven |
| loop_en_n | input | NCH | Per-channel loopback enable, active low |
| ext_pos | input | NCH | External line, one-level, per channel |
| ext_neg | input | NCH | External line, zero-level, per channel |
| rx_pos | output | NCH | Receiver feed, one-level, per channel |
| rx_neg | output | NCH | Receiver feed, zero-level, per channel |

## Verification
The assertions check, on every cycle, the following properties:
- The pair is null whenever the block is idle.
- Busy only ever falls from the trailing gap.
- The shift register and the latched rate hold still between divider ticks and while busy.
- A bad command code never starts a word.
- The divider count stays below its limit.

Only the bench's scenarios can show the following behaviours:
- The exact bit order and the half-period timing at both rates.
- The gap length.
- A mid-word command leaving the trace unchanged.
- The per-channel loopback selection, swept across many enable and external-input patterns.

// File: rtl/a429_st_pkg.sv
package a429_st_pkg;
    localparam logic [3:0] CODE_FAST = 4'h8;
    localparam logic [3:0] CODE_SLOW = 4'h9;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_MARK  = 2'd1,
        PH_SPACE = 2'd2,
        PH_GAP   = 2'd3
    } phase_e;
endpackage

// File: rtl/a429_st_divider.sv
module a429_st_divider #(
    parameter int HALF_FAST = 250,
    parameter int HALF_SLOW = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic rate_slow,
    output logic tick
);
    localparam int MAXH  = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
    localparam int CNT_W = $clog2(MAXH + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = rate_slow ? CNT_W'(HALF_SLOW - 1) : CNT_W'(HALF_FAST - 1);
        tick  = run && (cnt_q == limit);
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2 R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAXH - 1));
endmodule

// File: rtl/a429_st_serializer.sv
module a429_st_serializer
    import a429_st_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int GAP_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_code,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              tick,
    output logic              busy,
    output logic              rate_slow,
    output logic              line_pos,
    output logic              line_neg
);
    localparam int GAP_HALVES = 2 * GAP_BITS;
    localparam int IDX_MAX    = (WORD_W > GAP_HALVES) ? WORD_W : GAP_HALVES;
    localparam int IDX_W      = $clog2(IDX_MAX + 1);

    typedef struct packed {
        phase_e            phase;
        logic [WORD_W-1:0] shreg;
        logic [IDX_W-1:0]  idx;
        logic              slow;
    } ser_state_t;

    ser_state_t s_d, s_q;
    logic       code_ok;
    logic       accept;

    always_comb begin
        s_d     = s_q;
        code_ok = (cmd_code == CODE_FAST) || (cmd_code == CODE_SLOW);
        accept  = cmd_valid && code_ok && (s_q.phase == PH_IDLE);
        unique case (s_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    s_d.phase = PH_MARK;
                    s_d.shreg = cmd_word;
                    s_d.idx   = '0;
                    s_d.slow  = (cmd_code == CODE_SLOW);
                end
            end
            PH_MARK: begin
                if (tick) s_d.phase = PH_SPACE;
            end
            PH_SPACE: begin
                if (tick) begin
                    if (s_q.idx == IDX_W'(WORD_W - 1)) begin
                        s_d.phase = PH_GAP;
                        s_d.idx   = '0;
                    end else begin
                        s_d.phase = PH_MARK;
                        s_d.idx   = s_q.idx + 1'b1;
                        s_d.shreg = s_q.shreg >> 1;
                    end
                end
            end
            PH_GAP: begin
                if (tick) begin
                    if (s_q.idx == IDX_W'(GAP_HALVES - 1)) begin
                        s_d.phase = PH_IDLE;
                        s_d.idx   = '0;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase <= PH_IDLE;
            s_q.shreg <= '0;
            s_q.idx   <= '0;
            s_q.slow  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.phase != PH_IDLE);
    assign rate_slow = s_q.slow;
    assign line_pos  = (s_q.phase == PH_MARK) &&  s_q.shreg[0];
    assign line_neg  = (s_q.phase == PH_MARK) && !s_q.shreg[0];

    // R10
    idle_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!line_pos && !line_neg));

    // R6
    busy_fall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(s_q.phase) == PH_GAP));

    // R7
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(s_q.shreg));

    // R7
    rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> $stable(rate_slow));

    // R8
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && !code_ok) |=> !busy);
endmodule

// File: rtl/a429_st_loopmux.sv
module a429_st_loopmux #(
    parameter int NCH = 8
) (
    input  logic           ser_pos,
    input  logic           ser_neg,
    input  logic [NCH-1:0] loop_en_n,
    input  logic [NCH-1:0] ext_pos,
    input  logic [NCH-1:0] ext_neg,
    output logic [NCH-1:0] rx_pos,
    output logic [NCH-1:0] rx_neg
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign rx_pos[c] = loop_en_n[c] ? ext_pos[c] : ser_pos;
        assign rx_neg[c] = loop_en_n[c] ? ext_neg[c] : ser_neg;
    end
endmodule

// File: rtl/a429_st_tx.sv
module a429_st_tx #(
    parameter int CLK_HZ   = 50_000_000,
    parameter int HI_BPS   = 100_000,
    parameter int LO_BPS   = 12_500,
    parameter int WORD_W   = 32,
    parameter int GAP_BITS = 4,
    parameter int NCH      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_code,
    input  logic [WORD_W-1:0] cmd_word,
    output logic              busy,
    output logic              line_pos,
    output logic              line_neg,
    input  logic [NCH-1:0]    loop_en_n,
    input  logic [NCH-1:0]    ext_pos,
    input  logic [NCH-1:0]    ext_neg,
    output logic [NCH-1:0]    rx_pos,
    output logic [NCH-1:0]    rx_neg
);
    localparam int HALF_FAST = CLK_HZ / (2 * HI_BPS);
    localparam int HALF_SLOW = CLK_HZ / (2 * LO_BPS);

    logic tick;
    logic rate_slow;

    a429_st_divider #(
        .HALF_FAST(HALF_FAST),
        .HALF_SLOW(HALF_SLOW)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .rate_slow(rate_slow),
        .tick     (tick)
    );

    a429_st_serializer #(
        .WORD_W  (WORD_W),
        .GAP_BITS(GAP_BITS)
    ) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_code (cmd_code),
        .cmd_word (cmd_word),
        .tick     (tick),
        .busy     (busy),
        .rate_slow(rate_slow),
        .line_pos (line_pos),
        .line_neg (line_neg)
    );

    a429_st_loopmux #(
        .NCH(NCH)
    ) u_mux (
        .ser_pos  (line_pos),
        .ser_neg  (line_neg),
        .loop_en_n(loop_en_n),
        .ext_pos  (ext_pos),
        .ext_neg  (ext_neg),
        .rx_pos   (rx_pos),
        .rx_neg   (rx_neg)
    );

    // R5
    pair_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_pos && line_neg));
endmodule

// File: tb/a429_st_tx_bench.sv
module a429_st_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 400_000;
    localparam int HI_BPS     = 100_000;
    localparam int LO_BPS     = 12_500;
    localparam int NCH        = 8;
    localparam int H_FAST     = CLK_HZ / (2 * HI_BPS);
    localparam int H_SLOW     = CLK_HZ / (2 * LO_BPS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [3:0] cmd_code = 4'h0;
    logic [31:0] cmd_word = '0;
    logic busy, line_pos, line_neg;
    logic [NCH-1:0] loop_en_n = '1;
    logic [NCH-1:0] ext_pos = '0;
    logic [NCH-1:0] ext_neg = '0;
    logic [NCH-1:0] rx_pos, rx_neg;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    a429_st_tx #(
        .CLK_HZ(CLK_HZ), .HI_BPS(HI_BPS), .LO_BPS(LO_BPS),
        .WORD_W(32), .GAP_BITS(4), .NCH(NCH)
    ) u_a429_st_tx (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_word(cmd_word), .busy(busy), .line_pos(line_pos), .line_neg(line_neg),
        .loop_en_n(loop_en_n), .ext_pos(ext_pos), .ext_neg(ext_neg),
        .rx_pos(rx_pos), .rx_neg(rx_neg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Sends one word and checks the whole trace cycle by cycle.
    task automatic send_word(input logic [3:0] code, input logic [31:0] w, input int half);
        logic exp_pos, exp_neg, exp_busy, mark;
        int b;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code; cmd_word = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int j = 0; j <= 72 * half; j++) begin
            // R7: a new fast load of the inverted word in mid-flight
            cmd_valid = (j == 10);
            cmd_code  = 4'h8;
            cmd_word  = ~w;
            loop_en_n = NCH'(j * 37 + 3);
            ext_pos   = NCH'(j * 13 + 5);
            ext_neg   = NCH'(j * 7 + 1);
            #1;
            if (j < 64 * half) begin
                b = j / (2 * half);
                mark = (j % (2 * half)) < half;
                exp_pos = mark && w[b];
                exp_neg = mark && !w[b];
                exp_busy = 1'b1;
            end else begin
                exp_pos = 1'b0; exp_neg = 1'b0;
                exp_busy = (j < 72 * half);
            end
            // R2 R3 R4 R5 R7 R11: pair follows the word in LSB-first order
            check(code == 4'h8 ? "R2/R4/R5/R11" : "R3/R4/R5/R11",
                  {30'd0, line_pos, line_neg}, {30'd0, exp_pos, exp_neg});
            // R6: busy through the gap, low after it
            check("R6", {31'd0, busy}, {31'd0, exp_busy});
            // R9: per-channel selection
            for (int c = 0; c < NCH; c++) begin
                check("R9", {30'd0, rx_pos[c], rx_neg[c]},
                      loop_en_n[c] ? {30'd0, ext_pos[c], ext_neg[c]}
                                   : {30'd0, exp_pos, exp_neg});
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150_000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        // R1: reset holds everything null and idle, even with a command
        cmd_valid = 1'b1; cmd_code = 4'h8; cmd_word = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R1", {29'd0, busy, line_pos, line_neg}, 32'd0);
        cmd_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle output is null
        check("R10", {29'd0, busy, line_pos, line_neg}, 32'd0);

        // R8: every code other than 8 and 9 is ignored
        for (int k = 0; k < 16; k++) begin
            if (k == 8 || k == 9) continue;
            @(negedge clk);
            cmd_valid = 1'b1; cmd_code = 4'(k); cmd_word = 32'h1234_5678;
            @(negedge clk);
            cmd_valid = 1'b0;
            repeat (2) begin
                check("R8", {29'd0, busy, line_pos, line_neg}, 32'd0);
                @(negedge clk);
            end
        end

        send_word(4'h8, 32'hA5A5_0F3C, H_FAST);
        send_word(4'h8, 32'h0000_0000, H_FAST);
        send_word(4'h8, 32'hFFFF_FFFF, H_FAST);
        send_word(4'h8, 32'h8000_0001, H_FAST);
        for (int s = 0; s < 6; s++)
            send_word(4'h8, 32'h1 << (s * 6), H_FAST);
        send_word(4'h9, 32'h3C96_E107, H_SLOW);
        send_word(4'h9, 32'h0000_0001, H_SLOW);

        // R10: null again after the last word
        repeat (3) @(negedge clk);
        check("R10", {29'd0, busy, line_pos, line_neg}, 32'd0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule